// File: doc/BRIEF.md
# Spike History Window and Network Step Sequencer

This block keeps the recent firing record of a discrete-time spiking network and paces the network clock. It holds the spike vectors of the last `DEPTH` steps in a delay line and shows all `N_NEURONS × DEPTH` bits as one flat window, so that every neuron sees every delayed spike in the same cycle. Before a run, initial spike vectors are written into the delay slots while the block is idle.

When `load_done` goes high, the sequencer starts a run of `num_steps` steps. In each step it pulses `upd_req` so the neuron array computes its next state. It then walks `nrn_addr` from 0 to `N_NEURONS-1` and captures the returned `nrn_fire` bit into that position of a new spike vector. Last, it commits: the delay line shifts by one slot and the new vector enters the newest slot. That vector appears on `spike_out` as the network spike train, with a one-cycle `spike_valid` pulse. After the last step, `done` stays high until `load_done` is released.

Top module: `spike_history_ctrl`

## Requirements
- R1: After reset the window is all zero, and `busy`, `done`, `upd_req` and `spike_valid` are 0.
- R2: In idle, `init_we` with `init_slot` = s (s < DEPTH) writes `init_vec` into window bits [s·N +: N], where slot 0 is the newest (one-step delay). The write is visible one cycle later. A slot value of DEPTH or more changes nothing.
- R3: `init_we` while the sequencer is not idle leaves the window unchanged.
- R4: The sequencer stays idle while `load_done` is low. With `load_done` high in idle and `num_steps` > 0, the next cycle shows `upd_req` = 1 for exactly one cycle and `busy` = 1.
- R5: After `upd_req`, `nrn_addr` takes the values 0, 1, …, N-1 on consecutive cycles. The `nrn_fire` value present while `nrn_addr` = k becomes bit k of that step's spike vector.
- R6: On a commit, slot d takes the old slot d-1 for every d ≥ 1, and slot 0 takes the assembled vector.
- R7: `spike_out` equals window slot 0. `spike_valid` is high for exactly the one cycle after each commit, and `spike_out` then holds that step's vector.
- R8: A run takes exactly `num_steps` steps of N+2 cycles each. In the cycle after the last commit, `done` = 1 and `busy` = 0. `done` holds until `load_done` is low, and then the block returns to idle.
- R9: Starting with `num_steps` = 0 goes straight to `done` with no `upd_req` and no window change.
- R10: The window does not change during the address walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_done | input | 1 | Weights and initial states are in place; starts a run and holds `done` |
| num_steps | input | STEP_W | Number of steps in a run, sampled at start |
| init_we | input | 1 | Initial-condition write strobe (idle only) |
| init_slot | input | SLOT_W | Delay slot to write; 0 is the newest |
| init_vec | input | N_NEURONS | Spike vector to preload |
| upd_req | output | 1 | One-cycle request for the neurons to compute the next state |
| nrn_addr | output | ADDR_W | Neuron whose firing bit is being collected |
| nrn_fire | input | 1 | Firing bit of the addressed neuron |
| window | output | N_NEURONS*DEPTH | All delayed spike states, slot-major |
| spike_out | output | N_NEURONS | Spike vector of the latest committed step |
| spike_valid | output | 1 | One-cycle pulse marking a new `spike_out` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished; held until `load_done` is low |

## Verification
The assertions check on every cycle the shifting of the delay slots at a commit, the stability of the window during the address walk and under writes made outside idle, the ordering from update request to address 0 and the increment of the address, the capture of each fired bit into its own position, and the agreement of `spike_out` with the assembled vector whenever `spike_valid` is high. The scenarios alone can show end-to-end behaviour. They cover the length of a run in steps and cycles, the preload values reaching the neurons, the rejection of out-of-range slots, the zero-step run, and the match between a known firing pattern per step and the resulting spike train and delayed window.

// File: rtl/spike_history_pkg.sv
package spike_history_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UPDATE,
    ST_COLLECT,
    ST_COMMIT,
    ST_HALT
  } step_state_t;

endpackage

// File: rtl/spk_step_ctrl.sv
module spk_step_ctrl
  import spike_history_pkg::*;
#(
  parameter int N_NEURONS = 8,
  parameter int STEP_W    = 8,
  localparam int ADDR_W   = (N_NEURONS > 1) ? $clog2(N_NEURONS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_done,
  input  logic [STEP_W-1:0] num_steps,
  output logic              upd_req,
  output logic              collect_en,
  output logic              commit_evt,
  output logic [ADDR_W-1:0] nrn_addr,
  output logic              idle,
  output logic              busy,
  output logic              done
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(N_NEURONS - 1);

  step_state_t       state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [STEP_W-1:0] left_q;

  // Arithmetic kept in functions so the bench can restate it independently.
  function automatic logic addr_is_last(input logic [ADDR_W-1:0] a);
    return a == LAST_ADDR;
  endfunction

  function automatic logic final_step(input logic [STEP_W-1:0] left);
    return left == STEP_W'(1);
  endfunction

  // Internal events named for the checks.
  logic start_evt;
  logic walk_end_evt;
  assign start_evt    = (state_q == ST_IDLE) && load_done;
  assign walk_end_evt = (state_q == ST_COLLECT) && addr_is_last(addr_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (load_done) state_d = (num_steps == '0) ? ST_HALT : ST_UPDATE;
      ST_UPDATE:  state_d = ST_COLLECT;
      ST_COLLECT: if (walk_end_evt) state_d = ST_COMMIT;
      ST_COMMIT:  state_d = final_step(left_q) ? ST_HALT : ST_UPDATE;
      ST_HALT:    if (!load_done) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_UPDATE)      addr_q <= '0;
      else if (state_q == ST_COLLECT) addr_q <= addr_q + ADDR_W'(1);
      if (start_evt)                 left_q <= num_steps;
      else if (state_q == ST_COMMIT) left_q <= left_q - STEP_W'(1);
    end
  end

  assign upd_req    = (state_q == ST_UPDATE);
  assign collect_en = (state_q == ST_COLLECT);
  assign commit_evt = (state_q == ST_COMMIT);
  assign idle       = (state_q == ST_IDLE);
  assign busy       = upd_req | collect_en | commit_evt;
  assign done       = (state_q == ST_HALT);
  assign nrn_addr   = addr_q;

  assert_upd_then_addr0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |=> (collect_en && nrn_addr == '0));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (collect_en && $past(collect_en)) |-> (nrn_addr == $past(nrn_addr) + ADDR_W'(1)));

  assert_addr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    collect_en |-> (nrn_addr <= LAST_ADDR));

  assert_upd_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |=> !upd_req);

  assert_done_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(commit_evt) || $past(idle)));

  assert_idle_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !load_done) |=> idle);

endmodule

// File: rtl/spk_vec_assembler.sv
module spk_vec_assembler #(
  parameter int N_NEURONS = 8,
  localparam int ADDR_W   = (N_NEURONS > 1) ? $clog2(N_NEURONS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 capture_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 bit_in,
  output logic [N_NEURONS-1:0] vec
);

  function automatic logic [N_NEURONS-1:0] merge_bit(
    input logic [N_NEURONS-1:0] v,
    input logic [ADDR_W-1:0]    a,
    input logic                 b
  );
    logic [N_NEURONS-1:0] r;
    r = v;
    for (int i = 0; i < N_NEURONS; i++) begin
      if (a == ADDR_W'(i)) r[i] = b;
    end
    return r;
  endfunction

  for (genvar i = 0; i < N_NEURONS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n || clear)                          vec[i] <= 1'b0;
      else if (capture_en && addr == ADDR_W'(i))    vec[i] <= bit_in;
    end
  end

  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> (vec == merge_bit($past(vec), $past(addr), $past(bit_in))));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (vec == '0));

endmodule

// File: rtl/spk_hist_buf.sv
module spk_hist_buf #(
  parameter int N_NEURONS = 8,
  parameter int DEPTH     = 2,
  localparam int SLOT_W   = $clog2(DEPTH) + 1,
  localparam int WIN_W    = N_NEURONS * DEPTH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init_en,
  input  logic [SLOT_W-1:0]    init_slot,
  input  logic [N_NEURONS-1:0] init_vec,
  input  logic                 commit,
  input  logic [N_NEURONS-1:0] new_vec,
  output logic [WIN_W-1:0]     window
);

  logic [N_NEURONS-1:0] slot_q [DEPTH];

  for (genvar d = 0; d < DEPTH; d++) begin : g_slot
    logic hit;
    assign hit = init_en && (init_slot == SLOT_W'(d));

    if (d == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)      slot_q[d] <= '0;
        else if (commit) slot_q[d] <= new_vec;
        else if (hit)    slot_q[d] <= init_vec;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n)      slot_q[d] <= '0;
        else if (commit) slot_q[d] <= slot_q[d-1];
        else if (hit)    slot_q[d] <= init_vec;
      end
    end

    assign window[d*N_NEURONS +: N_NEURONS] = slot_q[d];
  end

  logic init_valid;
  assign init_valid = init_en && (init_slot < SLOT_W'(DEPTH));

  assert_head_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (window[N_NEURONS-1:0] == $past(new_vec)));

  if (DEPTH > 1) begin : g_shift_chk
    assert_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (window[WIN_W-1:N_NEURONS] == $past(window[WIN_W-N_NEURONS-1:0])));
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !init_valid) |=> $stable(window));

endmodule

// File: rtl/spike_history_ctrl.sv
module spike_history_ctrl #(
  parameter int N_NEURONS = 8,
  parameter int DEPTH     = 2,
  parameter int STEP_W    = 8,
  localparam int SLOT_W   = $clog2(DEPTH) + 1,
  localparam int ADDR_W   = (N_NEURONS > 1) ? $clog2(N_NEURONS) : 1,
  localparam int WIN_W    = N_NEURONS * DEPTH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_done,
  input  logic [STEP_W-1:0]    num_steps,
  input  logic                 init_we,
  input  logic [SLOT_W-1:0]    init_slot,
  input  logic [N_NEURONS-1:0] init_vec,
  output logic                 upd_req,
  output logic [ADDR_W-1:0]    nrn_addr,
  input  logic                 nrn_fire,
  output logic [WIN_W-1:0]     window,
  output logic [N_NEURONS-1:0] spike_out,
  output logic                 spike_valid,
  output logic                 busy,
  output logic                 done
);

  logic                 collect_en;
  logic                 commit_evt;
  logic                 idle;
  logic                 init_en;
  logic [N_NEURONS-1:0] asm_vec;

  spk_step_ctrl #(
    .N_NEURONS (N_NEURONS),
    .STEP_W    (STEP_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_done  (load_done),
    .num_steps  (num_steps),
    .upd_req    (upd_req),
    .collect_en (collect_en),
    .commit_evt (commit_evt),
    .nrn_addr   (nrn_addr),
    .idle       (idle),
    .busy       (busy),
    .done       (done)
  );

  spk_vec_assembler #(
    .N_NEURONS (N_NEURONS)
  ) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (upd_req),
    .capture_en (collect_en),
    .addr       (nrn_addr),
    .bit_in     (nrn_fire),
    .vec        (asm_vec)
  );

  // Initial conditions are accepted only while the sequencer rests.
  assign init_en = init_we && idle;

  spk_hist_buf #(
    .N_NEURONS (N_NEURONS),
    .DEPTH     (DEPTH)
  ) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_en   (init_en),
    .init_slot (init_slot),
    .init_vec  (init_vec),
    .commit    (commit_evt),
    .new_vec   (asm_vec),
    .window    (window)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) spike_valid <= 1'b0;
    else        spike_valid <= commit_evt;
  end

  assign spike_out = window[N_NEURONS-1:0];

  assert_init_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (init_we && !idle) |=> $stable(window));

  assert_valid_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spike_valid |-> (spike_out == $past(asm_vec)));

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spike_valid |=> !spike_valid);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  assert_walk_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    collect_en |=> $stable(window));

endmodule

// File: tb/spike_history_ctrl_test.sv
`timescale 1ns/1ps
module spike_history_ctrl_test;

  localparam int N      = 8;
  localparam int D      = 2;
  localparam int STEP_W = 8;
  localparam int SLOT_W = $clog2(D) + 1;
  localparam int ADDR_W = $clog2(N);
  localparam int NSTEP  = 6;

  // Firing pattern returned by the neurons in each step (bit k = neuron k).
  localparam logic [N-1:0] FIRE_TBL [NSTEP] = '{8'h01, 8'h80, 8'hA5, 8'h00, 8'hFF, 8'h3C};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              load_done = 1'b0;
  logic [STEP_W-1:0] num_steps = '0;
  logic              init_we = 1'b0;
  logic [SLOT_W-1:0] init_slot = '0;
  logic [N-1:0]      init_vec = '0;
  logic [N-1:0]      cur_pat = '0;
  logic              nrn_fire;
  logic              upd_req, spike_valid, busy, done;
  logic [ADDR_W-1:0] nrn_addr;
  logic [N*D-1:0]    window;
  logic [N-1:0]      spike_out;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic [N-1:0] exp_h [D];

  always #2 clk = ~clk;

  // Behavioural neuron array: answers with the bit of the current pattern.
  assign nrn_fire = cur_pat[nrn_addr];

  spike_history_ctrl #(.N_NEURONS(N), .DEPTH(D), .STEP_W(STEP_W)) uut (
    .clk(clk), .rst_n(rst_n), .load_done(load_done), .num_steps(num_steps),
    .init_we(init_we), .init_slot(init_slot), .init_vec(init_vec),
    .upd_req(upd_req), .nrn_addr(nrn_addr), .nrn_fire(nrn_fire),
    .window(window), .spike_out(spike_out), .spike_valid(spike_valid),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [N*D-1:0] exp_window();
    logic [N*D-1:0] w;
    w = '0;
    for (int d = D - 1; d >= 0; d--) w = (w << N) | (N*D)'(exp_h[d]);
    return w;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic wait_valid();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (spike_valid) return;
    end
  endtask

  initial begin
    int last_cyc;
    logic saw;
    logic [N*D-1:0] snap;

    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {window, busy, done, upd_req, spike_valid}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {window, busy, done, upd_req, spike_valid}, '0);

    // Preload both slots.
    init_we = 1'b1; init_slot = 0; init_vec = 8'h5A;
    @(negedge clk);
    init_slot = 1; init_vec = 8'hC3;
    @(negedge clk);
    init_we = 1'b0;
    exp_h[0] = 8'h5A; exp_h[1] = 8'hC3;
    chk("R2 preload", window, exp_window());
    init_we = 1'b1; init_slot = 2; init_vec = 8'hFF;
    @(negedge clk);
    init_we = 1'b0;
    @(negedge clk);
    chk("R2 out-of-range slot", window, exp_window());

    // No start while load_done is low.
    saw = 1'b0;
    repeat (5) begin
      @(negedge clk);
      saw = saw | upd_req | busy;
    end
    chk("R4 idle without load_done", saw, 1'b0);

    // Start the run.
    num_steps = STEP_W'(NSTEP);
    cur_pat = FIRE_TBL[0];
    load_done = 1'b1;
    @(negedge clk);
    chk("R4 upd_req after start", {upd_req, busy}, 2'b11);
    snap = window;
    saw = 1'b0;
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      chk("R5 address walk", nrn_addr, k);
      if (upd_req) saw = 1'b1;
      if (k == 3) begin
        init_we = 1'b1; init_slot = 0; init_vec = 8'hE7;
      end else init_we = 1'b0;
      if (k == 5) chk("R3 write while busy ignored", window, snap);
    end
    init_we = 1'b0;
    chk("R4 upd_req one cycle", saw, 1'b0);
    chk("R10 window stable in walk", window, snap);

    // Table-driven steps.
    last_cyc = 0;
    for (int s = 0; s < NSTEP; s++) begin
      wait_valid();
      for (int d = D - 1; d > 0; d--) exp_h[d] = exp_h[d-1];
      exp_h[0] = FIRE_TBL[s];
      chk("R7 spike_out", {spike_valid, spike_out}, {1'b1, FIRE_TBL[s]});
      chk("R6 window shift", window, exp_window());
      if (s > 0) chk("R8 step length", cyc - last_cyc, N + 2);
      last_cyc = cyc;
      if (s == NSTEP - 1) chk("R8 done after last step", {done, busy}, 2'b10);
      else cur_pat = FIRE_TBL[s+1];
      @(negedge clk);
      chk("R7 valid single pulse", spike_valid, 1'b0);
    end

    repeat (3) @(negedge clk);
    chk("R8 done held, no more steps", {done, busy, upd_req, window}, {3'b100, exp_window()});
    load_done = 1'b0;
    @(negedge clk);
    chk("R8 return to idle", {done, busy}, 2'b00);

    // Zero-step run.
    num_steps = '0;
    load_done = 1'b1;
    saw = 1'b0;
    repeat (4) begin
      @(negedge clk);
      saw = saw | upd_req;
    end
    chk("R9 zero steps done", {done, saw, busy}, 3'b100);
    chk("R9 window untouched", window, exp_window());
    load_done = 1'b0;
    @(negedge clk);
    chk("R9 back to idle", done, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule